// File: doc/BRIEF.md
# UART Host Register Interface with Interrupt Identification

This block is the processor-side register front end of a 16550-compatible serial port. A host issues single-cycle read or write strobes with a small register offset. The block decodes each access and holds the enable, line-control, modem-control, scratch and baud divisor bytes. It also tracks the overrun and transmit-empty conditions. From these it forms a ranked interrupt identification byte and a level interrupt line.

The receive buffer and the modem status tracker sit outside the block. The block reads their status inputs and sends them pop, push, flush and read strobes. Transmission is treated as instantaneous: a data write in normal mode leaves at once on a transmit strobe, so the transmitter always reads as ready. Baud timing and bit shifting are handled elsewhere.

Top module: `uart_hostif`

## Requirements
- R1: After reset the divisor holds REF_HZ / DEF_BAUD / OVERSAMPLE (12 by default; low byte 0x0C, high byte 0x00). The enable, line-control, modem-control and scratch registers read 0x00, `irq` is low, and the identification byte reads 0x01.
- R2: While line-control bit 7 is set, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. Such a data-offset write produces no transmit or push strobe. While bit 7 is clear, offset 0 is data and offset 1 is the enable register.
- R3: The enable register keeps only bits [3:0] of a write: bit 0 receive, bit 1 transmit-empty, bit 2 line status, bit 3 modem. Line-control (offset 3) and scratch (offset 7) read back exactly as written.
- R4: The identification code (low nibble at offset 2) is chosen by fixed rank. Overrun with enable bit 2 gives 0x6. Otherwise receive data present with enable bit 0 gives 0xC. Otherwise a pending transmit-empty flag with enable bit 1 gives 0x2. Otherwise any of `msr_in[3:0]` set with enable bit 3 gives 0x0. Otherwise the code is 0x1.
- R5: Buffered receive data always reports code 0xC, never the plain data-available code 0x4.
- R6: A write to the data register sets the transmit-empty flag. A read of offset 2 that reports 0x2 clears it.
- R7: An offset-2 write stores FIFO mode from bit 0. `rx_flush` pulses during the write when bit 0 differs from the stored mode, or when bits 0 and 1 are both set. In FIFO mode the identification byte has bits [7:6] = 11.
- R8: A status read (offset 5) returns bit 5 and bit 6 set, bit 0 equal to `rx_not_empty`, and bit 1 as the overrun flag. The overrun flag is cleared by that read.
- R9: Writes to offsets 5 and 6 change nothing. Offsets 8 and above read 0xFF and ignore writes.
- R10: `irq` is high exactly when the identification code is not 0x1. It follows any change of state or inputs.
- R11: Modem control keeps bits [4:0]; bit 4 selects loopback. In loopback a data write pulses `rx_push` instead of `tx_valid`, and sets overrun if `rx_full` is high.
- R12: A data read pops the buffer and returns `rx_head` when `rx_not_empty` is high, and returns 0xFF with no pop when it is low. An offset-6 read returns `msr_in` and pulses `msr_rd`. Read data appears on `reg_rdata` in the cycle after the strobe. When read and write strobes coincide, the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| irq | output | 1 | Level interrupt request |
| rx_not_empty | input | 1 | Receive buffer holds at least one byte |
| rx_head | input | 8 | Oldest byte in the receive buffer |
| rx_full | input | 1 | Receive buffer cannot accept a byte |
| rx_pop | output | 1 | Remove the oldest receive byte |
| rx_push | output | 1 | Loopback byte into the receive buffer |
| rx_push_data | output | 8 | Byte carried with `rx_push` |
| rx_flush | output | 1 | Empty the receive buffer |
| fifo_en | output | 1 | FIFO mode selected |
| msr_in | input | 8 | Modem status byte, deltas in [3:0] |
| msr_rd | output | 1 | Modem status was read (clear deltas) |
| mcr_out | output | 5 | Modem-control register contents |
| tx_valid | output | 1 | Byte leaves the transmitter |
| tx_data | output | 8 | Byte carried with `tx_valid` |

## Verification
The bench uses the default parameters: ADDR_W of 4, and a 1843200 reference with 9600 baud at 16x oversampling. The 4-bit offset makes the unmapped range 8 to 15 reachable, so the 0xFF read and the dropped writes can be observed. The bench also writes to offset 15, whose low bits match the scratch offset, to show that aliasing does not happen. The default rates give a reset divisor of 12. A 16-byte receive buffer model that holds one byte outside FIFO mode makes both the refused-push overrun and the multi-byte no-overrun cases reachable.

// File: rtl/uart_hostif_pkg.sv
package uart_hostif_pkg;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IER  = 3'd1;
  localparam logic [2:0] OFS_IIR  = 3'd2;
  localparam logic [2:0] OFS_LCR  = 3'd3;
  localparam logic [2:0] OFS_MCR  = 3'd4;
  localparam logic [2:0] OFS_LSR  = 3'd5;
  localparam logic [2:0] OFS_MSR  = 3'd6;

  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;
  localparam int LCR_DLAB = 7;
  localparam int MCR_LOOP = 4;

  typedef enum logic [3:0] {
    IID_MODEM = 4'h0,
    IID_NONE  = 4'h1,
    IID_TXE   = 4'h2,
    IID_LINE  = 4'h6,
    IID_RXTO  = 4'hC
  } iid_e;

  typedef struct packed {
    logic data_wr;
    logic data_rd;
    logic dll_wr;
    logic dll_rd;
    logic dlh_wr;
    logic dlh_rd;
    logic ier_wr;
    logic ier_rd;
    logic iir_rd;
    logic fcr_wr;
    logic lcr_wr;
    logic lcr_rd;
    logic mcr_wr;
    logic mcr_rd;
    logic lsr_rd;
    logic msr_rd;
    logic scr_wr;
    logic scr_rd;
    logic unmapped_rd;
  } acc_s;

endpackage

// File: rtl/uart_hostif_dec.sv
module uart_hostif_dec
  import uart_hostif_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dlab,
  output acc_s              acc
);

  logic       in_map;
  logic       wr_ok;
  logic [2:0] lo;

  assign lo    = addr[2:0];
  assign wr_ok = wr & ~rd;

  generate
    if (ADDR_W > 3) begin : g_wide
      assign in_map = ~|addr[ADDR_W-1:3];
    end else begin : g_narrow
      assign in_map = 1'b1;
    end
  endgenerate

  always_comb begin
    acc = '0;
    if (!in_map) begin
      acc.unmapped_rd = rd;
    end else begin
      case (lo)
        OFS_DATA: begin
          if (dlab) begin
            acc.dll_rd = rd;
            acc.dll_wr = wr_ok;
          end else begin
            acc.data_rd = rd;
            acc.data_wr = wr_ok;
          end
        end
        OFS_IER: begin
          if (dlab) begin
            acc.dlh_rd = rd;
            acc.dlh_wr = wr_ok;
          end else begin
            acc.ier_rd = rd;
            acc.ier_wr = wr_ok;
          end
        end
        OFS_IIR: begin
          acc.iir_rd = rd;
          acc.fcr_wr = wr_ok;
        end
        OFS_LCR: begin
          acc.lcr_rd = rd;
          acc.lcr_wr = wr_ok;
        end
        OFS_MCR: begin
          acc.mcr_rd = rd;
          acc.mcr_wr = wr_ok;
        end
        OFS_LSR: acc.lsr_rd = rd;
        OFS_MSR: acc.msr_rd = rd;
        default: begin
          acc.scr_rd = rd;
          acc.scr_wr = wr_ok;
        end
      endcase
    end
  end

endmodule

// File: rtl/uart_hostif_regs.sv
module uart_hostif_regs
  import uart_hostif_pkg::*;
#(
  parameter logic [15:0] DIV_RESET = 16'd12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  acc_s       acc,
  input  logic [7:0] wdata,
  input  logic       rx_full,
  input  logic       tx_reported,
  output logic [3:0] ier_q,
  output logic [7:0] lcr_q,
  output logic [4:0] mcr_q,
  output logic [7:0] scr_q,
  output logic [7:0] dll_q,
  output logic [7:0] dlh_q,
  output logic       fifo_en_q,
  output logic       oe_q,
  output logic       thre_q,
  output logic       rx_flush,
  output logic       rx_push,
  output logic       tx_valid
);

  logic oe_d, oe_en;
  logic thre_d, thre_en;
  logic loop;

  // next-state logic
  always_comb begin
    loop     = mcr_q[MCR_LOOP];
    rx_push  = acc.data_wr & loop;
    tx_valid = acc.data_wr & ~loop;
    rx_flush = acc.fcr_wr & ((wdata[0] ^ fifo_en_q) | (wdata[0] & wdata[1]));

    oe_en    = acc.lsr_rd | (rx_push & rx_full);
    oe_d     = ~acc.lsr_rd;

    thre_en  = acc.data_wr | (acc.iir_rd & tx_reported);
    thre_d   = acc.data_wr;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q     <= '0;
      lcr_q     <= '0;
      mcr_q     <= '0;
      scr_q     <= '0;
      dll_q     <= DIV_RESET[7:0];
      dlh_q     <= DIV_RESET[15:8];
      fifo_en_q <= 1'b0;
      oe_q      <= 1'b0;
      thre_q    <= 1'b0;
    end else begin
      if (acc.ier_wr) ier_q     <= wdata[3:0];
      if (acc.lcr_wr) lcr_q     <= wdata;
      if (acc.mcr_wr) mcr_q     <= wdata[4:0];
      if (acc.scr_wr) scr_q     <= wdata;
      if (acc.dll_wr) dll_q     <= wdata;
      if (acc.dlh_wr) dlh_q     <= wdata;
      if (acc.fcr_wr) fifo_en_q <= wdata[0];
      if (oe_en)      oe_q      <= oe_d;
      if (thre_en)    thre_q    <= thre_d;
    end
  end

endmodule

// File: rtl/uart_hostif_irqid.sv
module uart_hostif_irqid
  import uart_hostif_pkg::*;
(
  input  logic [3:0] ier,
  input  logic       oe,
  input  logic       rx_not_empty,
  input  logic       thre,
  input  logic [3:0] msr_delta,
  input  logic       fifo_en,
  output logic [7:0] iir_byte,
  output logic       irq,
  output logic       tx_reported
);

  iid_e       code;
  logic [3:0] code_bits;

  always_comb begin
    if (oe && ier[EN_LINE]) begin
      code = IID_LINE;
    end else if (rx_not_empty && ier[EN_RX]) begin
      code = IID_RXTO;
    end else if (thre && ier[EN_TX]) begin
      code = IID_TXE;
    end else if ((|msr_delta) && ier[EN_MODEM]) begin
      code = IID_MODEM;
    end else begin
      code = IID_NONE;
    end
  end

  assign code_bits   = code;
  assign iir_byte    = {(fifo_en ? 2'b11 : 2'b00), 2'b00, code_bits};
  assign irq         = (code != IID_NONE);
  assign tx_reported = (code == IID_TXE);

endmodule

// File: rtl/uart_hostif_rdmux.sv
module uart_hostif_rdmux
  import uart_hostif_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  acc_s       acc,
  input  logic [3:0] ier,
  input  logic [7:0] lcr,
  input  logic [4:0] mcr,
  input  logic [7:0] scr,
  input  logic [7:0] dll,
  input  logic [7:0] dlh,
  input  logic       oe,
  input  logic [7:0] iir_byte,
  input  logic [7:0] msr_in,
  input  logic [7:0] rx_head,
  input  logic       rx_not_empty,
  output logic [7:0] rdata_q
);

  logic [7:0] lsr_byte;
  logic [7:0] rd_val;

  assign lsr_byte = {1'b0, 1'b1, 1'b1, 3'b000, oe, rx_not_empty};

  always_comb begin
    rd_val = 8'hFF;
    if (acc.data_rd)      rd_val = rx_not_empty ? rx_head : 8'hFF;
    else if (acc.dll_rd)  rd_val = dll;
    else if (acc.dlh_rd)  rd_val = dlh;
    else if (acc.ier_rd)  rd_val = {4'h0, ier};
    else if (acc.iir_rd)  rd_val = iir_byte;
    else if (acc.lcr_rd)  rd_val = lcr;
    else if (acc.mcr_rd)  rd_val = {3'b000, mcr};
    else if (acc.lsr_rd)  rd_val = lsr_byte;
    else if (acc.msr_rd)  rd_val = msr_in;
    else if (acc.scr_rd)  rd_val = scr;
    else if (acc.unmapped_rd) rd_val = 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rd_val;
    end
  end

endmodule

// File: rtl/uart_hostif.sv
module uart_hostif
  import uart_hostif_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int REF_HZ     = 1843200,
  parameter int DEF_BAUD   = 9600,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  input  logic              rx_not_empty,
  input  logic [7:0]        rx_head,
  input  logic              rx_full,
  output logic              rx_pop,
  output logic              rx_push,
  output logic [7:0]        rx_push_data,
  output logic              rx_flush,
  output logic              fifo_en,
  input  logic [7:0]        msr_in,
  output logic              msr_rd,
  output logic [4:0]        mcr_out,
  output logic              tx_valid,
  output logic [7:0]        tx_data
);

  localparam int          DIV_VAL   = REF_HZ / DEF_BAUD / OVERSAMPLE;
  localparam logic [15:0] DIV_RESET = 16'(DIV_VAL);

  acc_s       acc;
  logic [3:0] ier_w;
  logic [7:0] lcr_w;
  logic [4:0] mcr_w;
  logic [7:0] scr_w;
  logic [7:0] dll_w;
  logic [7:0] dlh_w;
  logic       oe_w;
  logic       thre_w;
  logic       tx_rep_w;
  logic [7:0] iir_w;

  uart_hostif_dec #(.ADDR_W(ADDR_W)) u_dec (
    .rd   (reg_rd),
    .wr   (reg_wr),
    .addr (reg_addr),
    .dlab (lcr_w[LCR_DLAB]),
    .acc  (acc)
  );

  uart_hostif_regs #(.DIV_RESET(DIV_RESET)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc         (acc),
    .wdata       (reg_wdata),
    .rx_full     (rx_full),
    .tx_reported (tx_rep_w),
    .ier_q       (ier_w),
    .lcr_q       (lcr_w),
    .mcr_q       (mcr_w),
    .scr_q       (scr_w),
    .dll_q       (dll_w),
    .dlh_q       (dlh_w),
    .fifo_en_q   (fifo_en),
    .oe_q        (oe_w),
    .thre_q      (thre_w),
    .rx_flush    (rx_flush),
    .rx_push     (rx_push),
    .tx_valid    (tx_valid)
  );

  uart_hostif_irqid u_irqid (
    .ier          (ier_w),
    .oe           (oe_w),
    .rx_not_empty (rx_not_empty),
    .thre         (thre_w),
    .msr_delta    (msr_in[3:0]),
    .fifo_en      (fifo_en),
    .iir_byte     (iir_w),
    .irq          (irq),
    .tx_reported  (tx_rep_w)
  );

  uart_hostif_rdmux u_rdmux (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_en        (reg_rd),
    .acc          (acc),
    .ier          (ier_w),
    .lcr          (lcr_w),
    .mcr          (mcr_w),
    .scr          (scr_w),
    .dll          (dll_w),
    .dlh          (dlh_w),
    .oe           (oe_w),
    .iir_byte     (iir_w),
    .msr_in       (msr_in),
    .rx_head      (rx_head),
    .rx_not_empty (rx_not_empty),
    .rdata_q      (reg_rdata)
  );

  assign rx_pop       = acc.data_rd & rx_not_empty;
  assign msr_rd       = acc.msr_rd;
  assign mcr_out      = mcr_w;
  assign rx_push_data = reg_wdata;
  assign tx_data      = reg_wdata;

endmodule

// File: rtl/uart_hostif_chk.sv
module uart_hostif_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              dlab,
  input logic [3:0]        ier,
  input logic              rx_not_empty,
  input logic              rx_pop,
  input logic              rx_push,
  input logic              tx_valid,
  input logic              irq,
  input logic              thre,
  input logic              oe,
  input logic              fifo_en,
  input logic [7:0]        rdata
);

  // R5
  rx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_not_empty && ier[0]) |-> irq);

  // R6
  thre_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_rd && reg_addr == ADDR_W'(0) && !dlab) |=> thre);

  // R8
  oe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(5)) |=> !oe);

  // R12
  pop_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> rx_not_empty);

  // R2
  dlab_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(0) && dlab) |-> (!tx_valid && !rx_push));

  // R7
  iir_fifo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(2) && fifo_en) |=> (rdata[7:6] == 2'b11));

endmodule

bind uart_hostif uart_hostif_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_rd       (reg_rd),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .dlab         (lcr_w[7]),
  .ier          (ier_w),
  .rx_not_empty (rx_not_empty),
  .rx_pop       (rx_pop),
  .rx_push      (rx_push),
  .tx_valid     (tx_valid),
  .irq          (irq),
  .thre         (thre_w),
  .oe           (oe_w),
  .fifo_en      (fifo_en),
  .rdata        (reg_rdata)
);

// File: tb/uart_hostif_tb_top.sv
module uart_hostif_tb_top;

  localparam int HALF = 2;
  localparam int NV   = 27;

  // {kind(0=write,1=read-check), offset, data/expected, requirement}
  localparam logic [23:0] VEC [NV] = '{
    {4'd0, 4'h3, 8'h80, 8'd2},   // R2 set divisor access
    {4'd1, 4'h0, 8'h0C, 8'd1},   // R1 reset divisor low
    {4'd1, 4'h1, 8'h00, 8'd1},   // R1 reset divisor high
    {4'd0, 4'h0, 8'h34, 8'd2},   // R2
    {4'd0, 4'h1, 8'h12, 8'd2},   // R2
    {4'd1, 4'h0, 8'h34, 8'd2},   // R2
    {4'd1, 4'h1, 8'h12, 8'd2},   // R2
    {4'd1, 4'h3, 8'h80, 8'd3},   // R3 line control readback
    {4'd0, 4'h3, 8'h03, 8'd2},   // R2 clear divisor access
    {4'd1, 4'h0, 8'hFF, 8'd12},  // R12 empty data read
    {4'd1, 4'h1, 8'h00, 8'd2},   // R2 enable register visible again
    {4'd0, 4'h1, 8'hF5, 8'd3},   // R3
    {4'd1, 4'h1, 8'h05, 8'd3},   // R3 upper nibble dropped
    {4'd0, 4'h7, 8'hA7, 8'd3},   // R3 scratch
    {4'd1, 4'h7, 8'hA7, 8'd3},   // R3
    {4'd0, 4'h5, 8'hFF, 8'd9},   // R9 status write
    {4'd1, 4'h5, 8'h60, 8'd9},   // R9
    {4'd0, 4'h6, 8'hFF, 8'd9},   // R9 modem status write
    {4'd1, 4'h6, 8'h00, 8'd9},   // R9
    {4'd1, 4'h9, 8'hFF, 8'd9},   // R9 unmapped read
    {4'd0, 4'hF, 8'h55, 8'd9},   // R9 unmapped write
    {4'd1, 4'h7, 8'hA7, 8'd9},   // R9 scratch not aliased
    {4'd0, 4'h1, 8'h00, 8'd3},   // R3
    {4'd1, 4'h2, 8'h01, 8'd4},   // R4 nothing pending
    {4'd0, 4'h4, 8'hFF, 8'd11},  // R11
    {4'd1, 4'h4, 8'h1F, 8'd11},  // R11 modem control mask
    {4'd0, 4'h4, 8'h00, 8'd11}   // R11
  };

  logic       clk;
  logic       rst_n;
  logic       reg_rd;
  logic       reg_wr;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq;
  logic       rx_not_empty;
  logic [7:0] rx_head;
  logic       rx_full;
  logic       rx_pop;
  logic       rx_push;
  logic [7:0] rx_push_data;
  logic       rx_flush;
  logic       fifo_en;
  logic [7:0] msr_in;
  logic       msr_rd;
  logic [4:0] mcr_out;
  logic       tx_valid;
  logic [7:0] tx_data;

  int n_chk;
  int n_fail;
  bit done;

  uart_hostif dut_i (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .rx_not_empty(rx_not_empty), .rx_head(rx_head),
    .rx_full(rx_full), .rx_pop(rx_pop), .rx_push(rx_push),
    .rx_push_data(rx_push_data), .rx_flush(rx_flush), .fifo_en(fifo_en),
    .msr_in(msr_in), .msr_rd(msr_rd), .mcr_out(mcr_out),
    .tx_valid(tx_valid), .tx_data(tx_data)
  );

  initial clk = 1'b0;
  always #HALF clk = ~clk;

  // receive buffer model: 16 deep in FIFO mode, 1 deep otherwise
  logic [7:0] fmem [16];
  logic [4:0] fcnt;
  logic [3:0] frp;
  logic [4:0] fcap;

  assign fcap         = fifo_en ? 5'd16 : 5'd1;
  assign rx_full      = (fcnt >= fcap);
  assign rx_not_empty = (fcnt != 5'd0);
  assign rx_head      = fmem[frp];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt <= '0;
      frp  <= '0;
    end else if (rx_flush) begin
      fcnt <= '0;
      frp  <= '0;
    end else if (rx_push && !rx_full) begin
      fmem[frp + fcnt[3:0]] <= rx_push_data;
      fcnt <= fcnt + 5'd1;
    end else if (rx_pop) begin
      frp  <= frp + 4'd1;
      fcnt <= fcnt - 5'd1;
    end
  end

  // modem status model: deltas cleared by a status read
  logic       msr_load;
  logic [7:0] msr_new;
  logic [7:0] msr_reg;
  assign msr_in = msr_reg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)        msr_reg <= 8'h00;
    else if (msr_load) msr_reg <= msr_new;
    else if (msr_rd)   msr_reg <= msr_reg & 8'hF0;
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input int req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // write and capture {rx_push, tx_valid, rx_flush} during the write cycle
  task automatic wr_probe(input logic [3:0] a, input logic [7:0] d, output logic [7:0] snap);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    #1;
    snap = {5'b0, rx_push, tx_valid, rx_flush};
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] q);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    q = reg_rdata;
  endtask

  task automatic set_msr(input logic [7:0] v);
    @(negedge clk);
    msr_load = 1'b1; msr_new = v;
    @(negedge clk);
    msr_load = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input int req);
    logic [7:0] q;
    rd(a, q);
    chk(q, exp, req);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(2 * HALF * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 to R12: watchdog expired, actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] snap;
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    msr_load = 1'b0; msr_new = '0;
    repeat (3) @(negedge clk);
    chk({7'b0, irq}, 8'h00, 1);  // R1 irq low in reset
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][23:20] == 4'd0) wr(VEC[i][19:16], VEC[i][15:8]);
      else rd_chk(VEC[i][19:16], VEC[i][15:8], int'(VEC[i][7:0]));
    end

    // loopback, overrun and priority ranking
    wr(4'h4, 8'h10);
    wr(4'h1, 8'h01);
    chk({7'b0, irq}, 8'h00, 10);          // R10
    wr_probe(4'h0, 8'hA5, snap);
    chk(snap, 8'h04, 11);                 // R11 push, no transmit
    chk({7'b0, irq}, 8'h01, 10);          // R10
    rd_chk(4'h2, 8'h0C, 5);               // R5 timeout code
    wr(4'h1, 8'h05);
    wr_probe(4'h0, 8'h77, snap);          // refused push
    chk(snap, 8'h04, 11);                 // R11
    rd_chk(4'h2, 8'h06, 4);               // R4 line status ranks first
    rd_chk(4'h5, 8'h63, 8);               // R8
    rd_chk(4'h5, 8'h61, 8);               // R8 overrun cleared
    wr(4'h1, 8'h0F);
    set_msr(8'h31);
    rd_chk(4'h2, 8'h0C, 4);               // R4
    rd_chk(4'h0, 8'hA5, 12);              // R12 pop head
    rd_chk(4'h0, 8'hFF, 12);              // R12 empty
    rd_chk(4'h2, 8'h02, 6);               // R6 armed by data writes
    rd_chk(4'h2, 8'h00, 4);               // R4 modem last
    chk({7'b0, irq}, 8'h01, 10);          // R10
    rd_chk(4'h6, 8'h31, 12);              // R12 status passthrough
    rd_chk(4'h2, 8'h01, 4);               // R4
    chk({7'b0, irq}, 8'h00, 10);          // R10

    // normal transmit and transmit-empty flag
    wr(4'h4, 8'h00);
    wr(4'h1, 8'h02);
    wr_probe(4'h0, 8'h3C, snap);
    chk(snap, 8'h02, 11);                 // R11 transmit strobe
    chk({7'b0, irq}, 8'h01, 6);           // R6
    rd_chk(4'h2, 8'h02, 6);               // R6
    rd_chk(4'h2, 8'h01, 6);               // R6 cleared by the read
    chk({7'b0, irq}, 8'h00, 10);          // R10

    // FIFO mode control
    wr_probe(4'h2, 8'h01, snap);
    chk(snap, 8'h01, 7);                  // R7 flush on enable change
    chk({7'b0, fifo_en}, 8'h01, 7);       // R7
    rd_chk(4'h2, 8'hC1, 7);               // R7 upper bits
    wr_probe(4'h2, 8'h03, snap);
    chk(snap, 8'h01, 7);                  // R7 receive reset
    wr_probe(4'h2, 8'h01, snap);
    chk(snap, 8'h00, 7);                  // R7 no change, no flush
    wr(4'h4, 8'h10);
    wr(4'h1, 8'h00);
    wr(4'h0, 8'h11);
    wr(4'h0, 8'h22);
    wr(4'h0, 8'h33);
    rd_chk(4'h5, 8'h61, 7);               // R7 deep buffer, no overrun
    rd_chk(4'h0, 8'h11, 12);              // R12
    wr_probe(4'h2, 8'h00, snap);
    chk(snap, 8'h01, 7);                  // R7 flush on disable
    chk({7'b0, fifo_en}, 8'h00, 7);       // R7
    rd_chk(4'h5, 8'h60, 7);               // R7 flushed
    rd_chk(4'h2, 8'h01, 7);               // R7 upper bits clear

    // reset returns defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk({7'b0, irq}, 8'h00, 1);           // R1
    rst_n = 1'b1;
    rd_chk(4'h3, 8'h00, 1);               // R1
    rd_chk(4'h4, 8'h00, 1);               // R1
    rd_chk(4'h1, 8'h00, 1);               // R1
    rd_chk(4'h7, 8'h00, 1);               // R1
    wr(4'h3, 8'h80);
    rd_chk(4'h0, 8'h0C, 1);               // R1
    rd_chk(4'h1, 8'h00, 1);               // R1
    wr(4'h3, 8'h00);
    rd_chk(4'h2, 8'h01, 1);               // R1

    done = 1'b1;
    summary();
    $finish;
  end

endmodule